// File: doc/BRIEF.md
# Oversampled Serial Receive Channel with Status Byte

This block is the receive half of an asynchronous serial channel. It watches a serial input line, uses a clock enable that pulses at sixteen times the bit rate, and assembles characters of five to eight data bits. It checks optional parity and one stop bit. A finished character is held in a data register, and a data-available flag is raised in an 8-bit status byte that the host polls.

The status byte brings several kinds of information together at fixed bit positions. Bit 0 is data-available. Bits 1 to 3 are passed through from the companion transmitter and the channel's command logic. Bit 4 shows the carrier-detect input as it is right now. Bits 5 to 7 are sticky flags for break, parity error and overrun. The host takes a character with a one-cycle read strobe. The sticky flags are cleared only by a one-cycle error-reset strobe. The framing format comes from a 4-bit format word shared with the transmitter.

Top module: `serial_rx_status`

## Requirements
- R1: While reset is asserted, and directly after it, status bits 0, 5, 6 and 7 are 0 and `rx_data` is 0.
- R2: Status bit 1 equals `tx_ready`, bit 2 equals `cmd_busy`, bit 3 equals `tx_pending` and bit 4 equals `dcd`, all combinationally and without latching.
- R3: The line is sampled once per `tick`. A low level starts a frame only if the line is still low 8 ticks after the first low sample. A shorter low pulse produces no character and changes no flag.
- R4: The data length is 5 + `cfg[1:0]`. Data bits arrive least significant bit first and are right-aligned in `rx_data` with the unused upper bits at 0. `cfg` is captured when a start bit is accepted, so a change of `cfg` during a frame does not affect that frame.
- R5: `cfg[2]` = 1 enables a parity bit after the data bits. `cfg[3]` = 1 selects even parity and 0 selects odd parity. A parity mismatch on a frame with a high stop bit sets status bit 6, and the character is still delivered.
- R6: A frame with a high stop bit that completes while status bit 0 is clear loads `rx_data` and sets status bit 0. `rd_stb` clears bit 0. If a character completes in the same cycle as `rd_stb`, the new character is loaded and bit 0 stays set.
- R7: A frame with a high stop bit that completes while status bit 0 is set and no read is strobed sets status bit 7. The new character is discarded and `rx_data` keeps the unread character.
- R8: A frame whose data bits, parity bit (if any) and stop bit are all low sets status bit 5 and delivers no character. The receiver then starts no new frame until the line has been seen high.
- R9: A low stop bit with any data or parity bit high discards the frame and changes no status bit. The receiver also waits for the line to go high before it accepts a new start bit.
- R10: Status bits 5 to 7 stay set until `err_clr` is pulsed, which clears all three. An error detected in the same cycle as `err_clr` leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Enable pulse at 16 times the bit rate |
| rx | input | 1 | Serial input line, idle high |
| cfg | input | 4 | Format: [1:0] length minus 5, [2] parity enable, [3] even parity |
| dcd | input | 1 | Carrier-detect level, shown in status bit 4 |
| tx_ready | input | 1 | Transmitter can take a byte, shown in status bit 1 |
| cmd_busy | input | 1 | Command active on the channel, shown in status bit 2 |
| tx_pending | input | 1 | Transmit buffer not empty, shown in status bit 3 |
| rd_stb | input | 1 | One-cycle pulse: host takes the character |
| err_clr | input | 1 | One-cycle pulse: clear the sticky error flags |
| rx_data | output | 8 | Last delivered character, right-aligned |
| status | output | 8 | Status byte |

## Verification
Status bits 1 to 4 follow their inputs in the same cycle, so the bench samples them at the next falling edge after it drives them. The two-flop input synchronizer and the sampling at mid-stop-bit mean a character or flag settles about half a bit time before the bench finishes driving the stop bit. The bench therefore samples at the falling edge right after the last stop tick, which is far from any edge where the result could still be moving. `rd_stb` and `err_clr` act on the rising edge that follows their one-cycle pulse, and the bench samples one falling edge later. A reference model in the bench, built from the format word, predicts every field, and directed glitch, break, framing and mid-frame format-change cases run alongside seeded random frames.

// File: rtl/serial_rx_status.sv
`timescale 1ns/1ps
module serial_rx_status #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic [3:0] cfg,
  input  logic       dcd,
  input  logic       tx_ready,
  input  logic       cmd_busy,
  input  logic       tx_pending,
  input  logic       rd_stb,
  input  logic       err_clr,
  output logic [7:0] rx_data,
  output logic [7:0] status
);
  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] PH_MID = PW'(OSR / 2 - 1);
  localparam logic [PW-1:0] PH_END = PW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAIT} st_t;

  st_t st;
  logic [PW-1:0] ph;
  logic [2:0] cnt;
  logic [7:0] sh;
  logic [1:0] len_q;
  logic par_q, even_q, pbit;
  logic [1:0] sync;
  logic rx_s;
  logic avail, brk, perr, ovr;

  assign rx_s = sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx};

  logic [7:0] chr;
  logic fin, good, brk_ev, perr_ev, wr, ovr_ev;

  assign chr     = sh >> (2'd3 - len_q);
  assign fin     = tick && st == S_STOP && ph == PH_END;
  assign good    = fin && rx_s;
  assign brk_ev  = fin && !rx_s && chr == 8'd0 && !(par_q && pbit);
  assign perr_ev = good && par_q && (^chr ^ pbit ^ ~even_q);
  assign wr      = good && (!avail || rd_stb);
  assign ovr_ev  = good && avail && !rd_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; cnt <= '0; sh <= '0;
      len_q <= '0; par_q <= 1'b0; even_q <= 1'b0; pbit <= 1'b0;
    end else if (tick) begin
      case (st)
        S_IDLE:
          if (!rx_s) begin st <= S_START; ph <= '0; end
        S_START:
          if (ph == PH_MID) begin
            ph <= '0;
            if (!rx_s) begin
              st <= S_DATA; cnt <= '0; sh <= '0;
              len_q <= cfg[1:0]; par_q <= cfg[2]; even_q <= cfg[3]; pbit <= 1'b0;
            end else st <= S_IDLE;
          end else ph <= ph + 1'b1;
        S_DATA:
          if (ph == PH_END) begin
            ph <= '0;
            sh <= {rx_s, sh[7:1]};
            if (cnt == {1'b0, len_q} + 3'd4) st <= par_q ? S_PAR : S_STOP;
            else cnt <= cnt + 1'b1;
          end else ph <= ph + 1'b1;
        S_PAR:
          if (ph == PH_END) begin
            ph <= '0; pbit <= rx_s; st <= S_STOP;
          end else ph <= ph + 1'b1;
        S_STOP:
          if (ph == PH_END) begin
            ph <= '0;
            st <= rx_s ? S_IDLE : S_WAIT;
          end else ph <= ph + 1'b1;
        S_WAIT:
          if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail <= 1'b0; rx_data <= '0;
      brk <= 1'b0; perr <= 1'b0; ovr <= 1'b0;
    end else begin
      if (wr) begin
        rx_data <= chr;
        avail   <= 1'b1;
      end else if (rd_stb) avail <= 1'b0;
      brk  <= brk_ev  | (brk  & ~err_clr);
      perr <= perr_ev | (perr & ~err_clr);
      ovr  <= ovr_ev  | (ovr  & ~err_clr);
    end
  end

  assign status = {ovr, perr, brk, dcd, tx_pending, cmd_busy, tx_ready, avail};

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && !rd_stb) |=> $stable(rx_data)); // R7
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(avail)); // R7
  AST_AVAIL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(avail) |-> $past(rd_stb)); // R6
  AST_BRK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk) |-> $past(st) == S_STOP); // R8
  AST_WAIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !rx_s) |=> st == S_WAIT); // R8
  AST_STICKY_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !err_clr) |=> ovr); // R10
  AST_STICKY_PERR: assert property (@(posedge clk) disable iff (!rst_n)
    (perr && !err_clr) |=> perr); // R10
  AST_STICKY_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !err_clr) |=> brk); // R10
endmodule

// File: tb/serial_rx_status_bench.sv
`timescale 1ns/1ps
module serial_rx_status_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx = 1'b1;
  logic [3:0] cfg = 4'b0011;
  logic dcd = 1'b0, tx_ready = 1'b0, cmd_busy = 1'b0, tx_pending = 1'b0;
  logic rd_stb = 1'b0, err_clr = 1'b0;
  logic [7:0] rx_data, status;

  int errs = 0, checks = 0;
  logic avail_e = 1'b0, brk_e = 1'b0, pe_e = 1'b0, ovr_e = 1'b0;
  logic [7:0] data_e = 8'd0;

  serial_rx_status u_serial_rx_status (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx), .cfg(cfg), .dcd(dcd),
    .tx_ready(tx_ready), .cmd_busy(cmd_busy), .tx_pending(tx_pending),
    .rd_stb(rd_stb), .err_clr(err_clr), .rx_data(rx_data), .status(status));

  always #10 clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  end

  function automatic logic [7:0] exp_status();
    return {ovr_e, pe_e, brk_e, dcd, tx_pending, cmd_busy, tx_ready, avail_e};
  endfunction

  function automatic logic [7:0] mask_of(logic [1:0] l);
    return 8'hFF >> (2'd3 - l);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    @(negedge clk);
    chk(req, status, exp_status());
    if (avail_e) chk(req, rx_data, data_e);
  endtask

  task automatic wait_ticks(int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (tick) k++;
    end
  endtask

  task automatic bitout(logic b);
    @(negedge clk);
    rx = b;
    wait_ticks(16);
  endtask

  task automatic send(logic [7:0] d, logic [3:0] c, bit flip, bit stop_v, logic [3:0] c_mid);
    int n = 5 + int'(c[1:0]);
    logic [7:0] m = d & mask_of(c[1:0]);
    logic p = c[3] ? ^m : ~^m;
    if (flip) p = ~p;
    cfg = c;
    bitout(1'b0);
    cfg = c_mid;
    for (int i = 0; i < n; i++) bitout(m[i]);
    if (c[2]) bitout(p);
    bitout(stop_v);
    if (!stop_v) begin
      if (m == 8'd0 && !(c[2] && p)) brk_e = 1'b1;
    end else begin
      if (c[2] && flip) pe_e = 1'b1;
      if (avail_e) ovr_e = 1'b1;
      else begin data_e = m; avail_e = 1'b1; end
    end
    @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic do_read();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    avail_e = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    brk_e = 1'b0; pe_e = 1'b0; ovr_e = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #3000000;
    errs++; checks++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk_all("R1 in reset");
    rst_n = 1'b1;
    chk_all("R1 after reset");
    chk("R1 rx_data", rx_data, 8'd0);

    tx_ready = 1'b1; dcd = 1'b1;
    chk_all("R2 live bits");
    cmd_busy = 1'b1; tx_pending = 1'b1; dcd = 1'b0; tx_ready = 1'b0;
    chk_all("R2 live bits toggled");

    @(negedge clk); rx = 1'b0;
    wait_ticks(3);
    @(negedge clk); rx = 1'b1;
    wait_ticks(48);
    chk_all("R3 glitch rejected");

    send(8'hA5, 4'b0011, 1'b0, 1'b1, 4'b0011);
    chk_all("R6 8-bit char");
    send(8'h3C, 4'b0011, 1'b0, 1'b1, 4'b0011);
    chk_all("R7 overrun keeps data");
    do_read();
    chk_all("R6 read clears avail");
    send(8'h11, 4'b0011, 1'b0, 1'b1, 4'b0011);
    chk_all("R10 overrun flag stays");
    do_read();
    do_clr();
    chk_all("R10 err_clr");

    send(8'hF3, 4'b0000, 1'b0, 1'b1, 4'b0000);
    chk_all("R4 5-bit char");
    do_read();
    send(8'h5A, 4'b0011, 1'b0, 1'b1, 4'b0000);
    chk_all("R4 cfg captured at start");
    do_read();

    send(8'h47, 4'b0110, 1'b1, 1'b1, 4'b0110);
    chk_all("R5 odd parity error");
    do_read();
    send(8'h47, 4'b1110, 1'b0, 1'b1, 4'b1110);
    chk_all("R5 even parity ok");
    do_read();
    do_clr();

    send(8'h2B, 4'b0011, 1'b0, 1'b1, 4'b0011);
    @(negedge clk); rx = 1'b0;
    wait_ticks(16 * 10 + 60);
    brk_e = 1'b1;
    chk_all("R8 break flag");
    @(negedge clk); rx = 1'b1;
    wait_ticks(40);
    chk_all("R8 no char after break");
    do_read();
    send(8'h66, 4'b0011, 1'b0, 1'b1, 4'b0011);
    chk_all("R8 receive after break");
    do_read();
    do_clr();

    send(8'h55, 4'b0011, 1'b0, 1'b0, 4'b0011);
    wait_ticks(20);
    chk_all("R9 framing discard");
    send(8'h0F, 4'b0011, 1'b0, 1'b1, 4'b0011);
    chk_all("R9 recover after framing");
    do_read();

    for (int it = 0; it < 70; it++) begin
      logic [3:0] c = 4'($urandom % 16);
      int act = $urandom % 4;
      dcd = 1'($urandom); tx_ready = 1'($urandom);
      cmd_busy = 1'($urandom); tx_pending = 1'($urandom);
      send(8'($urandom), c, ($urandom % 6) == 0, 1'b1, c);
      chk_all("R5 R6 R7 random frame");
      if (act == 0) begin do_read(); chk_all("R6 random read"); end
      else if (act == 1) begin do_clr(); chk_all("R10 random clear"); end
    end
    finish_run();
  end
endmodule